// File: doc/BRIEF.md
# Streaming Separable Gaussian Smoother

This block smooths a raster image with a symmetric Gaussian kernel as the pixels stream past, one beat at a time. A horizontal pass convolves each row with a kernel of `2*RADIUS+1` taps. A vertical pass then applies the same kernel down each column of the horizontal result. Both passes run within one fused scan. The vertical pass keeps only `2*RADIUS+1` rows of width `IMG_W` in a circular set of row memories, so no frame store is needed. Only the row pointer moves from row to row; no row data is copied.

A frame is a scan of `(IMG_W+RADIUS)` columns by `(IMG_H+RADIUS)` rows in row order, one scan position per `in_valid` beat. Beats with column `>= IMG_W` or row `>= IMG_H` are padding. Their data is ignored, and they only push the pipeline forward. The result for image position (x, y) comes out one clock after the beat at scan position (x+RADIUS, y+RADIUS). Each frame therefore produces exactly `IMG_W*IMG_H` output beats in raster order.

Each pass divides its weighted sum by the constant `NORM_DIV` and truncates the result. The kernel half-weights and the divisor are parameters. Results within `RADIUS` of any image edge are forced to zero.

Top module: `gblur_sep`

## Requirements
- R1: The horizontal result at an interior pixel (x, y) is the sum over k = -RADIUS..RADIUS of w(|k|)·pixel(x+k, y), divided by NORM_DIV and truncated toward zero. The weight w(i) is the field i of COEFS (bits i·COEF_W upward). The default weights are w = 6, 4, 1 with NORM_DIV = 16.
- R2: The output at an interior pixel (x, y) is the sum over k of w(|k|)·h(x, y+k), divided by NORM_DIV and truncated. Here h is the horizontal result, which is zero wherever R3 applies.
- R3: Both the horizontal result and the output are zero at any pixel whose column is below RADIUS or above IMG_W-1-RADIUS, or whose row is below RADIUS or above IMG_H-1-RADIUS.
- R4: Each `in_valid` beat advances one scan position through (IMG_W+RADIUS) × (IMG_H+RADIUS) positions in row order, wrapping at the end. The `in_pix` value on a padding beat (column ≥ IMG_W or row ≥ IMG_H) has no effect on any output.
- R5: One clock after the beat at scan position (sx, sy) with sx ≥ RADIUS and sy ≥ RADIUS, `out_valid` is high with `out_x` = sx-RADIUS and `out_y` = sy-RADIUS. At all other times it is low. Each frame yields IMG_W·IMG_H output beats in raster order.
- R6: Cycles without `in_valid` change no state and produce no output; gaps anywhere in a frame leave the results unchanged.
- R7: A beat with `in_sof` high is taken as scan position (0, 0), whatever the counters held. This restarts the frame, including the row pointer, even in the middle of a frame.
- R8: When NORM_DIV is not a power of two, both passes use a true constant division with truncation. When it is a power of two, they use a shift.
- R9: While `rst_n` is low and on the first cycle after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One scan position is presented this cycle |
| in_sof | input | 1 | This beat is scan position (0, 0) |
| in_pix | input | PIX_W | Pixel value; ignored on padding beats |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | $clog2(IMG_W) | Column of the output pixel |
| out_y | output | $clog2(IMG_H) | Row of the output pixel |
| out_pix | output | PIX_W | Smoothed pixel value |

## Verification
A column counter that is off by one shows up at the first output of the next row: `out_x` breaks raster order within a single beat, and every later value is misaligned. A row pointer that points at the wrong slot leaves coordinates and border zeros correct but corrupts interior values from the first interior row onward, about RADIUS rows into the frame. A counter that ignores the start-of-frame flag is caught on the first output after a mid-frame restart. An error in the divider or the weights shows on any interior pixel of a non-flat image. A flat image at full scale exposes overflow at once.

// File: rtl/gblur_pkg.sv
package gblur_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned exact_log2(input int unsigned v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) begin
         if ((32'd1 << i) < v) n = i + 1;
      end
      return n;
   endfunction

endpackage

// File: rtl/gblur_dot.sv
module gblur_dot #(
   parameter int RADIUS = 2,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter logic [(RADIUS+1)*COEF_W-1:0] COEFS = {8'd1, 8'd4, 8'd6},
   parameter int unsigned NORM_DIV = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [(2*RADIUS+1)*PIX_W-1:0]    taps,
   output logic [PIX_W-1:0]                 res
);
   localparam int TAPS = 2 * RADIUS + 1;
   localparam int SW   = PIX_W + COEF_W + $clog2(TAPS) + 1;

   logic [SW-1:0] acc;
   logic [SW-1:0] quo;

   always_comb begin
      acc = '0;
      for (int j = 0; j < TAPS; j++) begin
         acc = acc + SW'(COEFS[((j < RADIUS) ? (RADIUS - j) : (j - RADIUS)) * COEF_W +: COEF_W])
                   * SW'(taps[j*PIX_W +: PIX_W]);
      end
   end

   generate
      if (gblur_pkg::is_pow2(NORM_DIV)) begin : g_shift
         assign quo = acc >> gblur_pkg::exact_log2(NORM_DIV);
      end else begin : g_divide
         assign quo = acc / SW'(NORM_DIV);
      end
   endgenerate

   assign res = quo[PIX_W-1:0];

   assert_fits_pixel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      quo <= SW'((2 ** PIX_W) - 1));

endmodule

// File: rtl/gblur_hwin.sv
module gblur_hwin #(
   parameter int RADIUS = 2,
   parameter int PIX_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shift_en,
   input  logic [PIX_W-1:0]              pix_in,
   output logic [(2*RADIUS+1)*PIX_W-1:0] taps
);
   localparam int DEPTH = 2 * RADIUS;

   logic [PIX_W-1:0] wnd [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) wnd[i] <= '0;
      end else if (shift_en) begin
         wnd[0] <= pix_in;
         for (int i = 1; i < DEPTH; i++) wnd[i] <= wnd[i-1];
      end
   end

   assign taps[0 +: PIX_W] = pix_in;
   generate
      for (genvar j = 1; j <= DEPTH; j++) begin : g_tap
         assign taps[j*PIX_W +: PIX_W] = wnd[j-1];
      end
   endgenerate

   assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(taps[(DEPTH+1)*PIX_W-1:PIX_W]));

endmodule

// File: rtl/gblur_lines.sv
module gblur_lines #(
   parameter int RADIUS = 2,
   parameter int PIX_W  = 8,
   parameter int IMG_W  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(2*RADIUS+1)-1:0] wr_row,
   input  logic [$clog2(IMG_W)-1:0]      col,
   input  logic [PIX_W-1:0]              wr_data,
   output logic [2*RADIUS*PIX_W-1:0]     older
);
   localparam int NL = 2 * RADIUS + 1;
   localparam int PW = $clog2(NL);

   logic [PIX_W-1:0] mem [NL][IMG_W];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row][col] <= wr_data;
   end

   generate
      for (genvar d = 1; d <= 2 * RADIUS; d++) begin : g_back
         logic [PW-1:0] slot;
         assign slot = PW'((int'(wr_row) + NL - d) % NL);
         assign older[(d-1)*PIX_W +: PIX_W] = mem[slot][col];
      end
   endgenerate

   assert_row_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_row) < NL));

endmodule

// File: rtl/gblur_sep.sv
module gblur_sep #(
   parameter int IMG_W  = 16,
   parameter int IMG_H  = 12,
   parameter int RADIUS = 2,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter logic [(RADIUS+1)*COEF_W-1:0] COEFS = {8'd1, 8'd4, 8'd6},
   parameter int unsigned NORM_DIV = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sof,
   input  logic [PIX_W-1:0]         in_pix,
   output logic                     out_valid,
   output logic [$clog2(IMG_W)-1:0] out_x,
   output logic [$clog2(IMG_H)-1:0] out_y,
   output logic [PIX_W-1:0]         out_pix
);
   localparam int TAPS = 2 * RADIUS + 1;
   localparam int NL   = TAPS;
   localparam int XW   = $clog2(IMG_W + RADIUS);
   localparam int YW   = $clog2(IMG_H + RADIUS);
   localparam int PW   = $clog2(NL);
   localparam int OXW  = $clog2(IMG_W);
   localparam int OYW  = $clog2(IMG_H);

   function automatic int unsigned kernel_total(input int r);
      int unsigned t;
      t = 0;
      for (int i = 0; i <= r; i++)
         t += ((i == 0) ? 1 : 2) * int'(COEFS[i*COEF_W +: COEF_W]);
      return t;
   endfunction
   localparam int unsigned KSUM = kernel_total(RADIUS);

   localparam logic [XW-1:0] X_LAG = XW'(RADIUS);
   localparam logic [XW-1:0] X_HI  = XW'(IMG_W - 1 - RADIUS);
   localparam logic [XW-1:0] X_END = XW'(IMG_W + RADIUS - 1);
   localparam logic [YW-1:0] Y_LAG = YW'(RADIUS);
   localparam logic [YW-1:0] Y_HI  = YW'(IMG_H - 1 - RADIUS);
   localparam logic [YW-1:0] Y_END = YW'(IMG_H + RADIUS - 1);
   localparam logic [PW-1:0] P_END = PW'(NL - 1);

   generate
      if (RADIUS < 1) begin : g_bad_radius
         $error("RADIUS must be at least 1");
      end
      if (IMG_W < TAPS || IMG_H < TAPS) begin : g_bad_size
         $error("image must span at least one full kernel each way");
      end
      if (NORM_DIV < KSUM) begin : g_bad_div
         $error("NORM_DIV below kernel total would overflow a pixel");
      end
   endgenerate

   logic [XW-1:0] xcnt, sx, cx;
   logic [YW-1:0] ycnt, sy, oy;
   logic [PW-1:0] wp, srow;

   assign sx   = in_sof ? '0 : xcnt;
   assign sy   = in_sof ? '0 : ycnt;
   assign srow = in_sof ? '0 : wp;
   assign cx   = sx - X_LAG;
   assign oy   = sy - Y_LAG;

   logic col_live, row_live, col_in, h_in, v_in, beat_out;
   assign col_live = (sx >= X_LAG);
   assign row_live = (sy >= Y_LAG);
   assign col_in   = col_live && (cx >= X_LAG) && (cx <= X_HI);
   assign h_in     = col_in && (sy >= Y_LAG) && (sy <= Y_HI);
   assign v_in     = col_in && row_live && (oy >= Y_LAG) && (oy <= Y_HI);
   assign beat_out = in_valid && col_live && row_live;

   // scan position and row pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xcnt <= '0;
         ycnt <= '0;
         wp   <= '0;
      end else if (in_valid) begin
         if (sx == X_END) begin
            xcnt <= '0;
            ycnt <= (sy == Y_END) ? '0 : sy + 1'b1;
            wp   <= (srow == P_END) ? '0 : srow + 1'b1;
         end else begin
            xcnt <= sx + 1'b1;
            ycnt <= sy;
            wp   <= srow;
         end
      end
   end

   // horizontal pass
   logic [TAPS*PIX_W-1:0] htaps;
   logic [PIX_W-1:0]      h_raw, h_val;

   gblur_hwin #(.RADIUS(RADIUS), .PIX_W(PIX_W)) u_hwin (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .pix_in(in_pix), .taps(htaps));

   gblur_dot #(.RADIUS(RADIUS), .PIX_W(PIX_W), .COEF_W(COEF_W), .COEFS(COEFS),
               .NORM_DIV(NORM_DIV)) u_hdot (
      .clk(clk), .rst_n(rst_n), .taps(htaps), .res(h_raw));

   assign h_val = h_in ? h_raw : '0;

   // row store and vertical pass
   logic [2*RADIUS*PIX_W-1:0] older;
   logic [TAPS*PIX_W-1:0]     vtaps;
   logic [PIX_W-1:0]          v_raw;

   gblur_lines #(.RADIUS(RADIUS), .PIX_W(PIX_W), .IMG_W(IMG_W)) u_lines (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid && col_live), .wr_row(srow),
      .col(cx[OXW-1:0]), .wr_data(h_val), .older(older));

   assign vtaps = {older, h_val};

   gblur_dot #(.RADIUS(RADIUS), .PIX_W(PIX_W), .COEF_W(COEF_W), .COEFS(COEFS),
               .NORM_DIV(NORM_DIV)) u_vdot (
      .clk(clk), .rst_n(rst_n), .taps(vtaps), .res(v_raw));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_x     <= '0;
         out_y     <= '0;
         out_pix   <= '0;
      end else begin
         out_valid <= beat_out;
         if (beat_out) begin
            out_x   <= cx[OXW-1:0];
            out_y   <= oy[OYW-1:0];
            out_pix <= v_in ? v_raw : '0;
         end
      end
   end

   assert_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_sof_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> !out_valid);

   assert_border_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ((int'(out_x) < RADIUS) || (int'(out_x) > IMG_W - 1 - RADIUS) ||
                     (int'(out_y) < RADIUS) || (int'(out_y) > IMG_H - 1 - RADIUS)))
      |-> (out_pix == '0));

   assert_raster_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && (out_x != '0))
      |-> ((out_x == $past(out_x) + 1'b1) && (out_y == $past(out_y))));

endmodule

// File: tb/gblur_sep_test.sv
module gblur_sep_test;
   localparam int N = 16;
   localparam int M = 12;
   localparam int R = 2;

   // stimulus table: {kind[7:5], gap[4], seed[3:0]}
   localparam logic [7:0] VEC [0:6] = '{8'h00, 8'h20, 8'h40, 8'h63, 8'h90, 8'h77, 8'hA0};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, in_valid, in_sof;
   logic [7:0] in_pix;
   logic       ova, ovb;
   logic [3:0] oxa, oya, oxb, oyb;
   logic [7:0] opa, opb;

   gblur_sep uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
      .out_valid(ova), .out_x(oxa), .out_y(oya), .out_pix(opa));

   gblur_sep #(.NORM_DIV(20)) uut_div (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
      .out_valid(ovb), .out_x(oxb), .out_y(oyb), .out_pix(opb));

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int idx [0:1];
   int img [0:M-1][0:N-1];
   int exv [0:1][0:M-1][0:N-1];
   string ftag = "R1 R2";
   logic beat_q = 1'b0;

   always @(posedge clk) beat_q <= in_valid;

   task automatic check(input bit ok, input string tag, input string what,
                        input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL R5 watchdog: got %0d cycles expected below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic int wt(input int k);
      int a;
      a = (k < 0) ? -k : k;
      return (a == 0) ? 6 : ((a == 1) ? 4 : 1);
   endfunction

   function automatic int pix_of(input int kind, input int seed, input int x, input int y);
      case (kind)
         0: return 255;
         1: return (x == 8 && y == 6) ? 255 : 0;
         2: return (x * 16 + y * 5) & 255;
         3: return ((x * 37) ^ (y * 91) ^ (seed * 29) ^ (x * y)) & 255;
         4: return ((x + y) & 1) ? 255 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic bit inner(input int x, input int y);
      return x >= R && x <= N - 1 - R && y >= R && y <= M - 1 - R;
   endfunction

   task automatic build(input int kind, input int seed);
      int hh [0:M-1][0:N-1];
      int s, d;
      for (int y = 0; y < M; y++)
         for (int x = 0; x < N; x++) img[y][x] = pix_of(kind, seed, x, y);
      for (int u = 0; u < 2; u++) begin
         d = (u == 0) ? 16 : 20;
         for (int y = 0; y < M; y++)
            for (int x = 0; x < N; x++) begin
               s = 0;
               if (inner(x, y))
                  for (int k = -R; k <= R; k++) s += wt(k) * img[y][x+k];
               hh[y][x] = s / d;
            end
         for (int y = 0; y < M; y++)
            for (int x = 0; x < N; x++) begin
               s = 0;
               if (inner(x, y))
                  for (int k = -R; k <= R; k++) s += wt(k) * hh[y+k][x];
               exv[u][y][x] = s / d;
            end
      end
   endtask

   task automatic mon(input int u, input logic v, input logic [3:0] ox,
                      input logic [3:0] oy, input logic [7:0] op);
      int ex, ey;
      string t;
      if (v) begin
         check(beat_q == 1'b1, "R6", "output without a beat", int'(beat_q), 1);
         ex = idx[u] % N;
         ey = idx[u] / N;
         check(int'(ox) == ex && int'(oy) == ey && idx[u] < N * M, "R5", "raster index",
               int'(oy) * N + int'(ox), idx[u]);
         if (int'(ox) < N && int'(oy) < M) begin
            if (!inner(int'(ox), int'(oy))) t = "R3";
            else if (u == 1) t = "R8";
            else t = ftag;
            check(int'(op) == exv[u][oy][ox], t, "pixel value", int'(op), exv[u][oy][ox]);
         end
         idx[u]++;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         mon(0, ova, oxa, oya, opa);
         mon(1, ovb, oxb, oyb, opb);
      end
   end

   task automatic drive_frame(input int kind, input int seed, input bit gap, input int rows);
      for (int y = 0; y < rows; y++) begin
         for (int x = 0; x < N + R; x++) begin
            if (gap && ((x + y) % 3 == 0)) begin
               in_valid = 1'b0;
               in_sof   = 1'b0;
               @(negedge clk);
            end
            in_valid = 1'b1;
            in_sof   = (x == 0 && y == 0);
            in_pix   = (x < N && y < M) ? 8'(pix_of(kind, seed, x, y)) : 8'(255 - x - y);
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      in_sof   = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_pix   = '0;
      idx[0]   = 0;
      idx[1]   = 0;
      repeat (3) @(negedge clk);
      // R9: quiet while in reset
      check(ova == 1'b0, "R9", "out_valid in reset", int'(ova), 0);
      check(ovb == 1'b0, "R9", "out_valid in reset (div)", int'(ovb), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ova == 1'b0, "R9", "out_valid after reset", int'(ova), 0);

      for (int i = 0; i < 7; i++) begin
         int kind, seed;
         bit gap;
         kind = int'(VEC[i][7:5]);
         gap  = VEC[i][4];
         seed = int'(VEC[i][3:0]);
         build(kind, seed);
         if (kind == 5) ftag = "R4";
         else if (gap) ftag = "R6";
         else ftag = "R1 R2";
         idx[0] = 0;
         idx[1] = 0;
         drive_frame(kind, seed, gap, M + R);
         check(idx[0] == N * M, "R5", "frame output count", idx[0], N * M);
         check(idx[1] == N * M, "R5", "frame output count (div)", idx[1], N * M);
      end

      // R7: abandon a frame after five scan rows, then restart with a new image
      build(2, 0);
      ftag   = "R7";
      idx[0] = 0;
      idx[1] = 0;
      drive_frame(2, 0, 1'b0, 5);
      check(idx[0] == 3 * N, "R7", "partial frame count", idx[0], 3 * N);
      build(3, 11);
      idx[0] = 0;
      idx[1] = 0;
      drive_frame(3, 11, 1'b0, M + R);
      check(idx[0] == N * M, "R7", "restarted frame count", idx[0], N * M);
      check(idx[1] == N * M, "R7", "restarted frame count (div)", idx[1], N * M);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule